// File: doc/BRIEF.md
# Floating-Point Compare and Classify Unit

This unit takes one or two IEEE-754 operands, in single or double precision, and produces either an 8-bit predicate or a data word. The predicate operations are quiet ordered compares (equal, greater-than, greater-or-equal), an unordered test, and a class test against a 5-bit mask. The data operations are minimum and maximum. A NaN result from these is replaced by an all-ones word instead of a canonical quiet NaN.

A request is presented with `in_valid_i`, an operation code, a precision select and the operands. The result, the updated status flags and an invalid indication appear one clock later with `out_valid_o`. The status flags pass through the unit. Compares leave them unchanged. A class test clears them. Minimum and maximum may set the invalid bit. Single-precision requests use only the low 32 bits of each operand.

Top module: `fp_cmp_class`

## Requirements
- R1: Each accepted request produces `out_valid_o` one cycle later. A predicate result is 0xFF in `result_o[7:0]` when true and 0x00 when false, and `result_o[63:8]` is zero.
- R2: Equal, greater-than and greater-or-equal (op codes 0, 1, 2) are false whenever either operand is a NaN. +0 and -0 compare equal.
- R3: For non-NaN operands, op 0 is true when a == b, op 1 when a > b, and op 2 when a >= b. This holds under IEEE ordering across negative values, subnormals and infinities.
- R4: The unordered test (op 3) is true exactly when at least one operand is a NaN, quiet or signalling.
- R5: The class test (op 4) examines operand a against the mask held in `opb_i[4:0]`. Mask bit 0 is zero, bit 1 is normal, bit 2 is subnormal, bit 3 is infinity and bit 4 is any NaN. The result is 0xFF when any selected class matches.
- R6: The class test drives `flags_o` to all zeros and `invalid_o` low.
- R7: Minimum (op 5) and maximum (op 6) return the numerically smaller or larger operand. If exactly one operand is a NaN, they return the other operand. If both are NaN, they return all ones across the precision's width.
- R8: When both operands are zeros of either sign, minimum returns the negative one if there is one, and maximum returns the positive one if there is one.
- R9: A double-precision minimum or maximum with any NaN input raises `invalid_o`. In that case `flags_o` equals `flags_i` with bit 0 set.
- R10: A single-precision minimum or maximum raises `invalid_o` (and sets bit 0 of `flags_o`) only when an input is a signalling NaN, that is, a NaN whose top fraction bit is 0.
- R11: Ops 0 to 3 copy `flags_i` to `flags_o` unchanged and keep `invalid_o` low.
- R12: While reset is asserted and after it, until the first request, `out_valid_o`, `result_o`, `flags_o` and `invalid_o` are all zero.
- R13: In single precision, `opa_i[63:32]` and `opb_i[63:32]` have no effect, and a single-precision data result has `result_o[63:32]` zero.
- R14: The reserved op code 7 returns a false predicate and passes `flags_i` through with `invalid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code (0 eq, 1 gt, 2 ge, 3 unordered, 4 class, 5 min, 6 max, 7 reserved) |
| dbl_i | input | 1 | 1 selects double precision, 0 single |
| opa_i | input | 64 | Operand a |
| opb_i | input | 64 | Operand b, or the class mask in bits 4:0 |
| flags_i | input | 5 | Status flags in; bit 0 is invalid |
| out_valid_o | output | 1 | Result strobe |
| result_o | output | 64 | Predicate or data result |
| flags_o | output | 5 | Status flags out |
| invalid_o | output | 1 | Invalid raised by this request |

## Verification
The hardest cases to reach are the ones where the operands are numerically equal, and in particular a +0 paired with a -0. Two independently drawn floating-point values almost never coincide, so the ordering and zero-sign rules would go unexercised. The random generator therefore often reuses operand a as operand b, either as is or with its sign flipped. It also draws from a narrow band of near-equal normals and weights zeros, subnormals, infinities and both kinds of NaN heavily. Directed cases add the signed-zero orderings, the NaN rules of minimum and maximum in each precision, and garbage in the upper half of single-precision operands.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

    localparam int PRED_W  = 8;
    localparam int CLASS_W = 5;
    localparam int INV_IDX = 0;

    typedef enum logic [2:0] {
        OP_EQ    = 3'd0,
        OP_GT    = 3'd1,
        OP_GE    = 3'd2,
        OP_UO    = 3'd3,
        OP_CLASS = 3'd4,
        OP_MIN   = 3'd5,
        OP_MAX   = 3'd6,
        OP_RSVD  = 3'd7
    } fpcc_op_e;

    typedef struct packed {
        logic sign;
        logic zero;
        logic normal;
        logic subnorm;
        logic inf;
        logic nan;
        logic snan;
    } fp_class_t;

endpackage

// File: rtl/fpcc_classify.sv
module fpcc_classify
    import fpcc_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] val_i,
    output fp_class_t            cls_o
);
    localparam int W = EXP_W + MAN_W + 1;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             exp_max, exp_min, man_nil;

    assign exp_f   = val_i[W-2:MAN_W];
    assign man_f   = val_i[MAN_W-1:0];
    assign exp_max = &exp_f;
    assign exp_min = ~|exp_f;
    assign man_nil = ~|man_f;

    always_comb begin
        cls_o.sign    = val_i[W-1];
        cls_o.zero    = exp_min & man_nil;
        cls_o.subnorm = exp_min & ~man_nil;
        cls_o.normal  = ~exp_min & ~exp_max;
        cls_o.inf     = exp_max & man_nil;
        cls_o.nan     = exp_max & ~man_nil;
        cls_o.snan    = exp_max & ~man_nil & ~man_f[MAN_W-1];
    end

    // every encoding falls in exactly one class
    always_comb begin
        assert_class_onehot_R5: assert ($onehot({cls_o.zero, cls_o.normal, cls_o.subnorm,
                                                  cls_o.inf, cls_o.nan}) || $isunknown(val_i));
    end

endmodule

// File: rtl/fpcc_order.sv
module fpcc_order
    import fpcc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  fp_class_t    ca_i,
    input  fp_class_t    cb_i,
    output logic         lt_o,
    output logic         eq_o,
    output logic         unord_o
);
    logic [W-2:0] mag_a, mag_b;
    logic         both_zero, mag_lt, mag_gt;

    assign mag_a     = a_i[W-2:0];
    assign mag_b     = b_i[W-2:0];
    assign both_zero = ca_i.zero & cb_i.zero;
    assign mag_lt    = mag_a < mag_b;
    assign mag_gt    = mag_a > mag_b;

    always_comb begin
        unord_o = ca_i.nan | cb_i.nan;
        eq_o    = ~unord_o & (both_zero | (a_i == b_i));
        lt_o    = 1'b0;
        if (!unord_o && !both_zero) begin
            if (ca_i.sign != cb_i.sign) begin
                lt_o = ca_i.sign;
            end else if (ca_i.sign) begin
                lt_o = mag_gt;
            end else begin
                lt_o = mag_lt;
            end
        end
    end

    always_comb begin
        assert_order_excl_R3: assert (!(lt_o && eq_o) || $isunknown({a_i, b_i}));
    end

endmodule

// File: rtl/fpcc_minmax.sv
module fpcc_minmax
    import fpcc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  fp_class_t    ca_i,
    input  fp_class_t    cb_i,
    input  logic         lt_i,
    input  logic         is_max_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        if (ca_i.nan && cb_i.nan) begin
            res_o = '1;
        end else if (ca_i.nan) begin
            res_o = b_i;
        end else if (cb_i.nan) begin
            res_o = a_i;
        end else if (ca_i.zero && cb_i.zero) begin
            // min prefers the negative zero, max the positive one
            if (is_max_i) begin
                res_o = ca_i.sign ? b_i : a_i;
            end else begin
                res_o = ca_i.sign ? a_i : b_i;
            end
        end else if (is_max_i) begin
            res_o = lt_i ? b_i : a_i;
        end else begin
            res_o = lt_i ? a_i : b_i;
        end
    end

endmodule

// File: rtl/fp_cmp_class.sv
module fp_cmp_class
    import fpcc_pkg::*;
#(
    parameter int SP_EXP = 8,
    parameter int SP_MAN = 23,
    parameter int DP_EXP = 11,
    parameter int DP_MAN = 52,
    parameter int DATA_W = DP_EXP + DP_MAN + 1,
    parameter int FLAG_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              in_valid_i,
    input  logic [2:0]        op_i,
    input  logic              dbl_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] result_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic              invalid_o
);
    localparam int NPREC = 2;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] result;
        logic [FLAG_W-1:0] flags;
        logic              inv;
    } state_t;

    state_t st_d, st_q;

    fpcc_op_e                      op_e;
    fp_class_t [NPREC-1:0]         cls_a, cls_b;
    logic [NPREC-1:0]              lt_v, eq_v, un_v;
    logic [NPREC-1:0][DATA_W-1:0]  mm_v;
    logic                          is_max;

    assign op_e   = fpcc_op_e'(op_i);
    assign is_max = (op_e == OP_MAX);

    for (genvar p = 0; p < NPREC; p++) begin : g_prec
        localparam int EW = (p == 0) ? SP_EXP : DP_EXP;
        localparam int MW = (p == 0) ? SP_MAN : DP_MAN;
        localparam int PW = EW + MW + 1;

        logic [PW-1:0] a_s, b_s, mm_s;

        assign a_s = opa_i[PW-1:0];
        assign b_s = opb_i[PW-1:0];

        fpcc_classify #(.EXP_W(EW), .MAN_W(MW)) u_cls_a (.val_i(a_s), .cls_o(cls_a[p]));
        fpcc_classify #(.EXP_W(EW), .MAN_W(MW)) u_cls_b (.val_i(b_s), .cls_o(cls_b[p]));

        fpcc_order #(.W(PW)) u_order (
            .a_i     (a_s),
            .b_i     (b_s),
            .ca_i    (cls_a[p]),
            .cb_i    (cls_b[p]),
            .lt_o    (lt_v[p]),
            .eq_o    (eq_v[p]),
            .unord_o (un_v[p])
        );

        fpcc_minmax #(.W(PW)) u_minmax (
            .a_i      (a_s),
            .b_i      (b_s),
            .ca_i     (cls_a[p]),
            .cb_i     (cls_b[p]),
            .lt_i     (lt_v[p]),
            .is_max_i (is_max),
            .res_o    (mm_s)
        );

        assign mm_v[p] = DATA_W'(mm_s);
    end

    fp_class_t          ca, cb;
    logic               lt_s, eq_s, un_s, gt_s;
    logic [CLASS_W-1:0] cls_mask, cls_hit;

    assign ca       = cls_a[dbl_i];
    assign cb       = cls_b[dbl_i];
    assign lt_s     = lt_v[dbl_i];
    assign eq_s     = eq_v[dbl_i];
    assign un_s     = un_v[dbl_i];
    assign gt_s     = ~un_s & ~eq_s & ~lt_s;
    assign cls_mask = opb_i[CLASS_W-1:0];
    assign cls_hit  = cls_mask & {ca.nan, ca.inf, ca.subnorm, ca.normal, ca.zero};

    logic              pred, is_pred, inv;
    logic [DATA_W-1:0] data_res;
    logic [FLAG_W-1:0] flg;

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid_i;
        pred       = 1'b0;
        is_pred    = 1'b1;
        inv        = 1'b0;
        data_res   = '0;
        flg        = flags_i;
        case (op_e)
            OP_EQ:    pred = eq_s;
            OP_GT:    pred = gt_s;
            OP_GE:    pred = gt_s | eq_s;
            OP_UO:    pred = un_s;
            OP_CLASS: begin
                pred = |cls_hit;
                flg  = '0;
            end
            OP_MIN, OP_MAX: begin
                is_pred  = 1'b0;
                data_res = mm_v[dbl_i];
                inv      = dbl_i ? (ca.nan | cb.nan) : (ca.snan | cb.snan);
                flg[INV_IDX] = flg[INV_IDX] | inv;
            end
            default:  pred = 1'b0;
        endcase
        if (in_valid_i) begin
            st_d.result = is_pred ? DATA_W'({PRED_W{pred}}) : data_res;
            st_d.flags  = flg;
            st_d.inv    = inv;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o = st_q.valid;
    assign result_o    = st_q.result;
    assign flags_o     = st_q.flags;
    assign invalid_o   = st_q.inv;

    assert_valid_follow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> out_valid_o);

    assert_pred_form_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && op_i <= 3'd4) |=>
        (result_o[DATA_W-1:PRED_W] == '0 &&
         (result_o[PRED_W-1:0] == '0 || result_o[PRED_W-1:0] == '1)));

    assert_quiet_nan_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && op_i <= 3'd2 && (ca.nan || cb.nan)) |=> (result_o == '0));

    assert_unord_nan_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && op_e == OP_UO && (ca.nan || cb.nan)) |=>
        (result_o[PRED_W-1:0] == '1));

    assert_class_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && op_e == OP_CLASS) |=> (flags_o == '0 && !invalid_o));

    assert_dp_invalid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && dbl_i && (op_e == OP_MIN || op_e == OP_MAX) && (ca.nan || cb.nan))
        |=> (invalid_o && flags_o[INV_IDX]));

    assert_flag_pass_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && op_i <= 3'd3) |=> (flags_o == $past(flags_i) && !invalid_o));

endmodule

// File: tb/tb_fp_cmp_class.sv
module tb_fp_cmp_class;

    localparam logic [2:0] C_EQ = 3'd0, C_GT = 3'd1, C_GE = 3'd2, C_UO = 3'd3,
                           C_CLS = 3'd4, C_MIN = 3'd5, C_MAX = 3'd6, C_RSV = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic        dbl = 1'b0;
    logic [63:0] opa = '0, opb = '0;
    logic [4:0]  fin = '0;
    logic        out_valid;
    logic [63:0] result;
    logic [4:0]  fout;
    logic        inval;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    fp_cmp_class dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .in_valid_i  (in_valid),
        .op_i        (op),
        .dbl_i       (dbl),
        .opa_i       (opa),
        .opb_i       (opb),
        .flags_i     (fin),
        .out_valid_o (out_valid),
        .result_o    (result),
        .flags_o     (fout),
        .invalid_o   (inval)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h (op=%0d dbl=%0d a=%h b=%h)", tag, got, exp, op, dbl, opa, opb);
        end
    endtask

    // field view of an operand in the chosen precision
    function automatic void fields(input logic [63:0] v, input bit d,
                                   output bit s, output bit zero, output bit sub,
                                   output bit norm, output bit inf, output bit nan,
                                   output bit snan, output longint ord);
        bit emax, emin, mnil, qb;
        longint mag;
        if (d) begin
            s = v[63]; emax = (v[62:52] == 11'h7FF); emin = (v[62:52] == 0);
            mnil = (v[51:0] == 0); qb = v[51]; mag = longint'({1'b0, v[62:0]});
        end else begin
            s = v[31]; emax = (v[30:23] == 8'hFF); emin = (v[30:23] == 0);
            mnil = (v[22:0] == 0); qb = v[22]; mag = longint'({33'b0, v[30:0]});
        end
        zero = emin & mnil; sub = emin & !mnil; norm = !emin & !emax;
        inf = emax & mnil; nan = emax & !mnil; snan = nan & !qb;
        ord = s ? -mag : mag;
    endfunction

    function automatic void ref_model(input logic [2:0] o, input bit d,
                                      input logic [63:0] a, input logic [63:0] b,
                                      input logic [4:0] fi, output logic [63:0] r,
                                      output logic [4:0] fo, output bit iv);
        bit sa, za, ua, na, ia, qa, xa, sb, zb, ub, nb, ib, qb, xb;
        longint oa, ob;
        logic [63:0] wm, am, bm;
        bit p;
        fields(a, d, sa, za, ua, na, ia, qa, xa, oa);
        fields(b, d, sb, zb, ub, nb, ib, qb, xb, ob);
        wm = d ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        am = a & wm; bm = b & wm;
        fo = fi; iv = 0; p = 0; r = '0;
        case (o)
            C_EQ: p = !(qa || qb) && (oa == ob);
            C_GT: p = !(qa || qb) && (oa > ob);
            C_GE: p = !(qa || qb) && (oa >= ob);
            C_UO: p = qa || qb;
            C_CLS: begin
                p = (b[0] && za) || (b[1] && na) || (b[2] && ua) || (b[3] && ia) || (b[4] && qa);
                fo = '0;
            end
            C_MIN, C_MAX: begin
                if (qa && qb) r = wm;
                else if (qa) r = bm;
                else if (qb) r = am;
                else if (za && zb) r = ((o == C_MIN) == sa) ? am : bm;
                else if (o == C_MIN) r = (oa <= ob) ? am : bm;
                else r = (oa >= ob) ? am : bm;
                iv = d ? (qa || qb) : (xa || xb);
                fo[0] = fi[0] | iv;
            end
            default: p = 0;
        endcase
        if (o != C_MIN && o != C_MAX) r = p ? 64'hFF : 64'h0;
    endfunction

    function automatic string res_tag(input logic [2:0] o);
        case (o)
            C_EQ, C_GT, C_GE: return "R3";
            C_UO:  return "R4";
            C_CLS: return "R5";
            C_MIN, C_MAX: return "R7";
            default: return "R14";
        endcase
    endfunction

    function automatic string flag_tag(input logic [2:0] o, input bit d);
        case (o)
            C_CLS: return "R6";
            C_MIN, C_MAX: return d ? "R9" : "R10";
            C_RSV: return "R14";
            default: return "R11";
        endcase
    endfunction

    // drive one request and check the registered outcome one cycle later
    task automatic run(input logic [2:0] o, input bit d, input logic [63:0] a,
                       input logic [63:0] b, input logic [4:0] fi, input string rtag);
        logic [63:0] er;
        logic [4:0]  ef;
        bit          ei;
        ref_model(o, d, a, b, fi, er, ef, ei);
        @(negedge clk);
        in_valid = 1; op = o; dbl = d; opa = a; opb = b; fin = fi;
        @(posedge clk);
        #1;
        in_valid = 0;
        @(negedge clk);
        check("R1", {63'b0, out_valid}, 64'd1);
        check(rtag == "" ? res_tag(o) : rtag, result, er);
        check(flag_tag(o, d), {58'b0, inval, fout}, {58'b0, ei, ef});
    endtask

    function automatic logic [63:0] rnd_fp(input bit d);
        int unsigned k;
        bit s;
        logic [63:0] v;
        logic [51:0] m;
        logic [10:0] e;
        k = $urandom % 8;
        s = $urandom % 2;
        m = {$urandom, $urandom};
        if (!d) m[51:23] = '0;
        case (k)
            0: begin e = 0; m = 0; end
            1: begin e = 0; m[0] = 1'b1; end
            2, 3: e = d ? 11'(1 + $urandom % 2046) : 11'(1 + $urandom % 254);
            4: begin e = '1; m = 0; end
            5: begin e = '1; if (d) m[51] = 1'b1; else m[22] = 1'b1; end
            6: begin e = '1; m[0] = 1'b1; if (d) m[51] = 1'b0; else m[22] = 1'b0; end
            default: begin e = d ? 11'(1023 + $urandom % 3) : 11'(127 + $urandom % 3); m = 52'($urandom % 4); end
        endcase
        if (d) v = {s, e, m};
        else   v = {$urandom, s, e[7:0], m[22:0]};
        return v;
    endfunction

    localparam logic [63:0] SP_PZ = 64'h0, SP_NZ = 64'h8000_0000;
    localparam logic [63:0] SP_ONE = 64'h3F80_0000, SP_TWO = 64'h4000_0000;
    localparam logic [63:0] SP_QN = 64'h7FC0_0000, SP_SN = 64'h7F80_0001;
    localparam logic [63:0] DP_ONE = 64'h3FF0_0000_0000_0000, DP_QN = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] DP_NZ = 64'h8000_0000_0000_0000, DP_NINF = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] DP_PINF = 64'h7FF0_0000_0000_0000, DP_SUB = 64'h0000_0000_0000_0001;

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R12: state held at zero during reset
        check("R12", {out_valid, inval, fout, result[56:0]}, 64'd0);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R12", {out_valid, inval, fout, result[56:0]}, 64'd0);

        // R2: signed zeros and NaN in the quiet compares
        run(C_EQ, 0, SP_PZ, SP_NZ, 5'h00, "R2");
        run(C_GT, 0, SP_PZ, SP_NZ, 5'h00, "R2");
        run(C_GE, 1, DP_NZ, 64'h0, 5'h00, "R2");
        run(C_EQ, 0, SP_QN, SP_QN, 5'h00, "R2");
        run(C_GE, 1, DP_QN, DP_ONE, 5'h00, "R2");
        // R3: ordering corners
        run(C_GT, 0, SP_TWO, SP_ONE, 5'h00, "R3");
        run(C_GT, 0, SP_ONE | SP_NZ, SP_TWO | SP_NZ, 5'h00, "R3");
        run(C_GT, 1, DP_PINF, DP_NINF, 5'h00, "R3");
        run(C_GT, 1, DP_SUB, 64'h0, 5'h00, "R3");
        // R4
        run(C_UO, 0, SP_ONE, SP_SN, 5'h0A, "R4");
        run(C_UO, 1, DP_ONE, DP_ONE, 5'h0A, "R4");
        // R5 / R6: class with all flags set on entry
        run(C_CLS, 0, SP_NZ, 64'h01, 5'h1F, "R5");
        run(C_CLS, 1, DP_SUB, 64'h1B, 5'h1F, "R5");
        run(C_CLS, 1, DP_SUB, 64'h04, 5'h1F, "R5");
        run(C_CLS, 0, SP_SN, 64'h10, 5'h1F, "R6");
        // R7: NaN handling in min/max
        run(C_MIN, 0, SP_QN, SP_TWO, 5'h00, "R7");
        run(C_MAX, 0, SP_QN, SP_SN, 5'h00, "R7");
        run(C_MAX, 1, DP_QN, DP_QN, 5'h00, "R7");
        // R8: signed zeros
        run(C_MIN, 0, SP_PZ, SP_NZ, 5'h00, "R8");
        run(C_MIN, 0, SP_NZ, SP_PZ, 5'h00, "R8");
        run(C_MAX, 1, DP_NZ, 64'h0, 5'h00, "R8");
        run(C_MAX, 1, 64'h0, DP_NZ, 5'h00, "R8");
        // R9 / R10: invalid raising
        run(C_MIN, 1, DP_QN, DP_ONE, 5'h04, "R9");
        run(C_MIN, 0, SP_QN, SP_ONE, 5'h04, "R10");
        run(C_MAX, 0, SP_ONE, SP_SN, 5'h04, "R10");
        // R13: garbage in upper halves of single operands
        run(C_EQ, 0, 64'hDEAD_BEEF_3F80_0000, 64'h1234_5678_3F80_0000, 5'h00, "R13");
        run(C_MAX, 0, 64'hFFFF_FFFF_3F80_0000, 64'hAAAA_AAAA_4000_0000, 5'h00, "R13");
        // R14: reserved op
        run(C_RSV, 1, DP_ONE, DP_ONE, 5'h15, "R14");

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            bit          d;
            logic [2:0]  o;
            logic [63:0] a, b;
            int unsigned sel;
            d = $urandom % 2;
            o = 3'($urandom % 8);
            a = rnd_fp(d);
            sel = $urandom % 4;
            if (sel == 0) b = a;
            else if (sel == 1) b = a ^ (d ? 64'h8000_0000_0000_0000 : 64'h8000_0000);
            else b = rnd_fp(d);
            if (o == C_CLS) b = {$urandom, $urandom};
            run(o, d, a, b, 5'($urandom % 32), "");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule